// File: doc/BRIEF.md
# Read-After-Write Hazard Guard

This block sits between a processor's simple request port and a slow register-mapped peripheral. It times each bus access itself, holding the access for a fixed number of clocks. It also enforces a minimum spacing between a completed write and the read that directly follows it. The spacing depends only on the address that the read targets. A small lookup table marks a few registers as safe to read at once. Every other address, including addresses the table does not know, must wait the full gap. The gap is given in nanoseconds and is turned into clocks at elaboration.

Clocks that pass between the end of the write and the arrival of the read count toward the gap, so the block only covers what is still missing. A mode input selects how the missing time is covered. In stall mode the block simply holds off the read. In filler mode it issues back-to-back harmless reads of the designated safe test register and discards their data. It issues as many of these as the remaining deficit, divided by the bus cycle length and rounded up, calls for. A saturating counter reports how many filler reads have been issued since reset.

The host raises `req_valid` and holds its request fields steady until `req_ready` pulses. That pulse marks the last clock of the host's own bus access.

Top module: `raw_gap_guard`

## Requirements
- R1: A write begins on the bus in the clock its request is presented and lasts BUS_CYCLE_CLKS clocks; `req_ready` is high only in the last of them (request-to-ready latency 4 clocks by default).
- R2: A read of a zero-wait address (defaults 0x00, 0x04, 0x08) that directly follows a write starts at once, with latency BUS_CYCLE_CLKS.
- R3: In stall mode (`dummy_mode`=0), a read of any other mapped address (0x10..0x30) directly after a write starts no earlier than WAIT_CLKS = ceil(GAP_NS/CLK_NS) clocks after the write's last bus clock (17 by default), and exactly then if it was already waiting.
- R4: A read of an address outside the lookup (for example 0x3C) is given the full gap, as in R3.
- R5: Idle clocks between the end of the write and the read request count toward the gap; only the remaining deficit is added, and none at all once the gap has passed.
- R6: The gap is only applied to the first read after a write; a read following a read (even a zero-wait read issued right after the write) starts at once.
- R7: In filler mode (`dummy_mode`=1), a read needing a deficit D is preceded by ceil(D/BUS_CYCLE_CLKS) back-to-back reads of TEST_ADDR (0x04) with `bus_we` low and no `req_ready`, and the host read starts right after them.
- R8: `dummy_count` rises by one for each filler read and holds at its all-ones value instead of wrapping.
- R9: After reset `bus_en`, `req_ready` and `dummy_count` are zero, and no write is considered pending, so the first read starts at once.
- R10: In the `req_ready` clock of a host read, `rsp_rdata` equals `bus_rdata` for the host's address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dummy_mode | input | 1 | 1 selects filler reads, 0 selects stalling |
| req_valid | input | 1 | Host request present, held until `req_ready` |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Host register address |
| req_wdata | input | DATA_W | Host write data |
| req_ready | output | 1 | Pulses on the last bus clock of the host access |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ready` on reads |
| bus_en | output | 1 | Peripheral access in progress |
| bus_we | output | 1 | Peripheral write strobe |
| bus_addr | output | ADDR_W | Peripheral address |
| bus_wdata | output | DATA_W | Peripheral write data |
| bus_rdata | input | DATA_W | Peripheral read data |
| dummy_count | output | DCNT_W | Saturating count of filler reads |

## Verification
The hardest case to reach is a read that arrives partway through the gap, because the number of filler reads then depends on exactly how many clocks the host idled after the write. The stimulus inserts a counted number of idle clocks after a completed write. It then checks both the read latency and the number of filler reads seen on the bus against the rounded-up deficit, at several offsets. Saturation of the filler counter is reached quickly by building the bench with a narrow counter and repeating full-deficit reads.

// File: rtl/rgg_pkg.sv
package rgg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOST  = 2'd1,
      ST_DUMMY = 2'd2
   } rgg_state_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/rgg_wait_lut.sv
module rgg_wait_lut #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned N_FREE    = 3,
   parameter logic [N_FREE*ADDR_W-1:0] FREE_ADDRS = '0,
   parameter int unsigned WAIT_CLKS = 17,
   parameter int unsigned CNT_W     = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  need
);

   logic [N_FREE-1:0] hit;

   for (genvar gi = 0; gi < N_FREE; gi++) begin : g_free
      assign hit[gi] = (addr == FREE_ADDRS[gi*ADDR_W +: ADDR_W]);
   end

   // Unknown addresses fall through to the full gap.
   assign need = (|hit) ? '0 : CNT_W'(WAIT_CLKS);

   always_comb begin
      a_r2_free_zero_wait : assert (!(|hit) || need == '0);
   end

endmodule

// File: rtl/rgg_gap_timer.sv
module rgg_gap_timer #(
   parameter int unsigned WAIT_CLKS = 17,
   parameter int unsigned CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_done,
   input  logic             rd_launch,
   output logic [CNT_W-1:0] since,
   output logic             pending
);

   localparam logic [CNT_W-1:0] SAT = CNT_W'(WAIT_CLKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since   <= SAT;
         pending <= 1'b0;
      end else begin
         if (wr_done)
            since <= '0;
         else if (since != SAT)
            since <= since + 1'b1;

         if (wr_done)
            pending <= 1'b1;
         else if (rd_launch)
            pending <= 1'b0;
      end
   end

   a_r5_elapsed_counts : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_done && since != SAT) |=> since == $past(since) + 1'b1);

   a_r6_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_launch && !wr_done) |=> !pending);

   a_r3_since_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      since <= SAT);

endmodule

// File: rtl/rgg_sat_counter.sv
module rgg_sat_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc && count != '1)
         count <= count + 1'b1;
   end

   a_r8_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      count == '1 |=> count == '1);

   a_r8_single_step : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && count != '1) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/raw_gap_guard.sv
module raw_gap_guard #(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned CLK_NS         = 10,
   parameter int unsigned GAP_NS         = 165,
   parameter int unsigned BUS_CYCLE_CLKS = 4,
   parameter int unsigned N_FREE         = 3,
   parameter logic [N_FREE*ADDR_W-1:0] FREE_ADDRS = {8'h08, 8'h04, 8'h00},
   parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h04,
   parameter int unsigned DCNT_W         = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dummy_mode,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_en,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DCNT_W-1:0] dummy_count
);

   import rgg_pkg::*;

   localparam int unsigned WAIT_CLKS = ceil_div(GAP_NS, CLK_NS);
   localparam int unsigned CNT_W     = $clog2(WAIT_CLKS + 1);
   localparam int unsigned BEAT_W    = $clog2(BUS_CYCLE_CLKS);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BUS_CYCLE_CLKS - 1);

   if (BUS_CYCLE_CLKS < 2) begin : g_chk_cycle
      $error("BUS_CYCLE_CLKS must be at least 2");
   end
   if (GAP_NS < 1 || CLK_NS < 1) begin : g_chk_time
      $error("GAP_NS and CLK_NS must be positive");
   end
   if (DCNT_W < 1 || N_FREE < 1) begin : g_chk_width
      $error("DCNT_W and N_FREE must be positive");
   end

   rgg_state_e        state;
   logic [BEAT_W-1:0] beat;
   logic [CNT_W-1:0]  need;
   logic [CNT_W-1:0]  since;
   logic              pending;
   logic              hazard;
   logic              host_go;
   logic              dummy_go;
   logic              launch;
   logic              act_dummy;
   logic              done;
   logic              wr_done;
   logic              rd_launch;

   rgg_wait_lut #(
      .ADDR_W    (ADDR_W),
      .N_FREE    (N_FREE),
      .FREE_ADDRS(FREE_ADDRS),
      .WAIT_CLKS (WAIT_CLKS),
      .CNT_W     (CNT_W)
   ) u_lut (
      .addr(req_addr),
      .need(need)
   );

   rgg_gap_timer #(
      .WAIT_CLKS(WAIT_CLKS),
      .CNT_W    (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_done  (wr_done),
      .rd_launch(rd_launch),
      .since    (since),
      .pending  (pending)
   );

   rgg_sat_counter #(
      .W(DCNT_W)
   ) u_dcnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (dummy_go),
      .count(dummy_count)
   );

   assign hazard   = pending && (need > since);
   assign host_go  = (state == ST_IDLE) && req_valid && (req_we || !hazard);
   assign dummy_go = (state == ST_IDLE) && req_valid && !req_we && hazard && dummy_mode;
   assign launch   = host_go || dummy_go;

   assign act_dummy = (state == ST_DUMMY) || dummy_go;
   assign done      = (state != ST_IDLE) && (beat == LAST_BEAT);

   assign wr_done   = done && (state == ST_HOST) && req_we;
   assign rd_launch = host_go && !req_we;

   assign bus_en    = launch || (state != ST_IDLE);
   assign bus_we    = bus_en && !act_dummy && req_we;
   assign bus_addr  = !bus_en ? '0 : (act_dummy ? TEST_ADDR : req_addr);
   assign bus_wdata = bus_we ? req_wdata : '0;

   assign req_ready = done && (state == ST_HOST);
   assign rsp_rdata = (req_ready && !req_we) ? bus_rdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         beat  <= '0;
      end else if (launch) begin
         state <= dummy_go ? ST_DUMMY : ST_HOST;
         beat  <= BEAT_W'(1);
      end else if (done) begin
         state <= ST_IDLE;
         beat  <= '0;
      end else if (state != ST_IDLE) begin
         beat  <= beat + 1'b1;
      end
   end

   a_r3_no_early_read : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_launch && pending) |-> since >= need);

   a_r7_filler_targets_test : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DUMMY) |-> (bus_en && !bus_we && bus_addr == TEST_ADDR && !req_ready));

   a_r1_ready_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   a_r1_bus_held : assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && !done) |=> bus_en);

endmodule

// File: tb/raw_gap_guard_tb.sv
module raw_gap_guard_tb;

   localparam int BC    = 4;
   localparam int WAITC = 17;
   localparam logic [7:0] TADDR = 8'h04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dummy_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] rsp_rdata;
   logic        bus_en;
   logic        bus_we;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [3:0]  dummy_count;

   int compared = 0;
   int mismatched = 0;
   int dummies_seen = 0;
   int bbeat = 0;

   always #5 clk = ~clk;

   assign bus_rdata = {16'hC0DE, 8'h00, bus_addr};

   raw_gap_guard #(.DCNT_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .dummy_mode(dummy_mode),
      .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dummy_count(dummy_count)
   );

   // Bus monitor: filler reads are reads of the test address while the host asks for another one.
   always @(negedge clk) begin
      if (!rst_n) begin
         bbeat = 0;
      end else if (bus_en) begin
         if (bbeat == 0 && !bus_we && bus_addr == TADDR && req_addr != TADDR)
            dummies_seen++;
         bbeat = (bbeat == BC - 1) ? 0 : bbeat + 1;
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic host_op(input logic we, input logic [7:0] addr, output int lat,
                          output logic [31:0] rd);
      @(posedge clk); #2;
      req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = {24'h5A5A5A, addr};
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!req_ready && lat < 300);
      rd = rsp_rdata;
   endtask

   task automatic idle(input int n);
      @(posedge clk); #2;
      req_valid = 1'b0;
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic set_mode(input logic m);
      @(posedge clk); #2;
      req_valid = 1'b0;
      dummy_mode = m;
   endtask

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   task automatic t_reset();
      int lat; logic [31:0] rd;
      @(negedge clk);
      chk("R9 ready", int'(req_ready), 0);
      chk("R9 bus_en", int'(bus_en), 0);
      chk("R9 count", int'(dummy_count), 0);
      host_op(1'b0, 8'h10, lat, rd);
      chk("R9 first read latency", lat, BC);
      chk("R10 read data", int'(rd == {16'hC0DE, 8'h00, 8'h10}), 1);
   endtask

   task automatic t_write();
      int lat; logic [31:0] rd;
      host_op(1'b1, 8'h20, lat, rd);
      chk("R1 write latency", lat, BC);
   endtask

   task automatic t_zero_wait();
      int lat; logic [31:0] rd;
      logic [7:0] free [3] = '{8'h00, 8'h04, 8'h08};
      foreach (free[i]) begin
         host_op(1'b1, 8'h10, lat, rd);
         host_op(1'b0, free[i], lat, rd);
         chk("R2 zero-wait read latency", lat, BC);
         chk("R10 zero-wait data", int'(rd == {16'hC0DE, 8'h00, free[i]}), 1);
      end
   endtask

   task automatic t_stall();
      int lat; logic [31:0] rd; int d0;
      d0 = dummies_seen;
      host_op(1'b1, 8'h14, lat, rd);
      host_op(1'b0, 8'h18, lat, rd);
      chk("R3 stalled read latency", lat, BC + WAITC);
      chk("R3 no filler in stall mode", dummies_seen - d0, 0);
   endtask

   task automatic t_unknown();
      int lat; logic [31:0] rd;
      host_op(1'b1, 8'h30, lat, rd);
      host_op(1'b0, 8'h3C, lat, rd);
      chk("R4 unmapped read latency", lat, BC + WAITC);
   endtask

   task automatic t_partial();
      int lat; logic [31:0] rd;
      host_op(1'b1, 8'h24, lat, rd);
      idle(10);
      host_op(1'b0, 8'h1C, lat, rd);
      chk("R5 partial deficit latency", lat, BC + WAITC - 10);
      host_op(1'b1, 8'h24, lat, rd);
      idle(25);
      host_op(1'b0, 8'h1C, lat, rd);
      chk("R5 gap already met", lat, BC);
   endtask

   task automatic t_read_read();
      int lat; logic [31:0] rd;
      host_op(1'b1, 8'h28, lat, rd);
      host_op(1'b0, 8'h00, lat, rd);
      chk("R6 first zero-wait read", lat, BC);
      host_op(1'b0, 8'h14, lat, rd);
      chk("R6 read after read", lat, BC);
   endtask

   task automatic t_filler();
      int lat; logic [31:0] rd; int d0; int c0;
      int offs [3] = '{0, 6, 17};
      set_mode(1'b1);
      foreach (offs[i]) begin
         int nd;
         nd = (offs[i] >= WAITC) ? 0 : cdiv(WAITC - offs[i], BC);
         d0 = dummies_seen;
         c0 = int'(dummy_count);
         host_op(1'b1, 8'h10, lat, rd);
         if (offs[i] > 0) idle(offs[i]);
         host_op(1'b0, 8'h2C, lat, rd);
         chk("R7 filler read count on bus", dummies_seen - d0, nd);
         chk("R7 read latency with fillers", lat, BC * (nd + 1));
         chk("R8 counter step", int'(dummy_count) - c0, nd);
         chk("R10 data after fillers", int'(rd == {16'hC0DE, 8'h00, 8'h2C}), 1);
      end
   endtask

   task automatic t_saturate();
      int lat; logic [31:0] rd;
      // 8 fillers so far; two more full-deficit reads add 10 and would reach 18.
      host_op(1'b1, 8'h10, lat, rd);
      host_op(1'b0, 8'h14, lat, rd);
      chk("R8 count before saturation", int'(dummy_count), 13);
      host_op(1'b1, 8'h10, lat, rd);
      host_op(1'b0, 8'h14, lat, rd);
      chk("R8 count saturates", int'(dummy_count), 15);
      host_op(1'b1, 8'h10, lat, rd);
      host_op(1'b0, 8'h14, lat, rd);
      chk("R8 count holds at max", int'(dummy_count), 15);
      chk("R7 fillers still issued", lat, BC * 6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_write();
      t_zero_wait();
      t_stall();
      t_unknown();
      t_partial();
      t_read_read();
      t_filler();
      t_saturate();
      idle(3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule